// File: doc/BRIEF.md
# Sync-Gated Serial Receive Bit FIFO

This block sits behind a clock-and-data recovery stage and receives one recovered bit per cycle in which its bit-valid strobe is high. While searching, it slides the incoming bits through a 16-bit window and compares them against a programmable synchronization word. The word's length can be set from 8 to 16 bits. Once the word is recognised, a status flag rises and every later valid bit is stored in a 16-entry, one-bit-wide first-in first-out store. The synchronization word itself is never stored.

A fill interrupt is high while the number of stored bits is at or above a threshold that can be set anywhere from 1 to 16. A host drains the store one bit per read clock while it holds the select line high. The host's select and read clock are sampled on the block's own clock. A clear input flushes the store and starts a new search.

Top module: `syncRxBitFifo`

## Requirements
- R1: The effective word length L is `syncLen` clamped to the range 8..16. The word is `syncPattern[L-1:0]`, and bit L-1 arrives first. `syncFound` rises on the clock edge that accepts the last bit of a matching window.
- R2: A match is declared only after at least L valid bits have been received since reset or clear. An all-zero word therefore does not match the zeroed window early.
- R3: No bit is stored before `syncFound` is high. The bits of the word are not stored, and the first stored bit is the valid bit that follows the last bit of the word.
- R4: `syncFound` stays high until `clear` or reset.
- R5: The store holds up to 16 bits and returns them in arrival order. A cycle with `bitValid` low stores nothing.
- R6: `fillIrq` is high exactly while the stored count is at least the effective threshold. The effective threshold is `fillThresh`, with 0 read as 1 and values above 16 read as 16. The output follows each push or pop on the same clock edge.
- R7: A rising edge of `hostSck` while `hostSel` is high pops the oldest bit onto `rdBit`, which is updated on the clock edge that samples the rise. When the store is empty, `rdBit` becomes 0 and nothing is removed.
- R8: Edges of `hostSck` while `hostSel` is low remove nothing and leave `rdBit` unchanged.
- R9: A valid bit arriving while 16 bits are held, with no pop in the same cycle, is dropped. It also sets `overflow`, which stays set until `clear`.
- R10: `clear` empties the store and drops `fillIrq`, `overflow` and `syncFound`. It also restarts the search with an empty window.
- R11: After reset, `rdBit`, `fillIrq`, `syncFound` and `overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous flush and restart of the search |
| bitIn | input | 1 | Recovered data bit |
| bitValid | input | 1 | Qualifies `bitIn` for one cycle |
| syncPattern | input | 16 | Synchronization word, right-aligned |
| syncLen | input | 5 | Word length, clamped to 8..16 |
| fillThresh | input | 5 | Interrupt threshold, clamped to 1..16 |
| hostSel | input | 1 | Host store-select line |
| hostSck | input | 1 | Host read clock, sampled by `clk` |
| rdBit | output | 1 | Bit most recently popped |
| fillIrq | output | 1 | Fill-level interrupt |
| syncFound | output | 1 | Synchronization word recognised |
| overflow | output | 1 | Sticky drop indicator |

## Verification
The bench sweeps every word length from 8 to 16 against every threshold from 1 to 16. A reference model follows the window, the store and the flags bit by bit. The first corner case is the interrupt edge: an off-by-one threshold compare would move `fillIrq` one bit early or late. The second is the bit that completes the word: if that bit leaked into the store, every later read would be shifted by one bit. The remaining cases are an all-zero word right after clear, which an unguarded matcher accepts before enough bits have arrived, and the clamp values for length and threshold. Two more cover overflow at exactly 16 bits, where a wrong full test corrupts order or misses the flag, and reads of an empty store or reads with the select line low, which must neither pop nor change `rdBit`.

// File: rtl/syncRxBitFifo_pkg.sv
package syncRxBitFifo_pkg;

  // Strobes issued by the control to the bit store, one cycle each.
  typedef struct packed {
    logic push;     // write bitIn at the tail
    logic pop;      // remove the head onto rdBit
    logic readEvt;  // a host read edge was seen (pop or empty read)
    logic drop;     // a bit was lost because the store is full
    logic flush;    // empty the store and clear sticky state
  } storeCmd_t;

endpackage

// File: rtl/syncMatcher.sv
module syncMatcher #(
  parameter int SYNC_W  = 16,
  parameter int MIN_LEN = 8,
  localparam int LEN_W  = $clog2(SYNC_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              bitValid,
  input  logic              bitIn,
  input  logic [SYNC_W-1:0] pattern,
  input  logic [LEN_W-1:0]  lenCfg,
  output logic              found
);

  logic [LEN_W-1:0]  effLen;
  logic [SYNC_W-1:0] lenMask;
  logic [SYNC_W-1:0] winQ, winNext;
  logic [LEN_W-1:0]  seenQ, seenNext;
  logic              hit;

  // Clamp the programmed length into the supported range (R1).
  always_comb begin
    if (lenCfg < LEN_W'(MIN_LEN))      effLen = LEN_W'(MIN_LEN);
    else if (lenCfg > LEN_W'(SYNC_W))  effLen = LEN_W'(SYNC_W);
    else                               effLen = lenCfg;
  end

  always_comb begin
    for (int i = 0; i < SYNC_W; i++) begin
      lenMask[i] = (i < int'(effLen));
    end
  end

  assign winNext  = {winQ[SYNC_W-2:0], bitIn};
  assign seenNext = (seenQ == LEN_W'(SYNC_W)) ? seenQ : seenQ + 1'b1;

  // A window is only trusted once enough bits have filled it (R2).
  assign hit = !found && bitValid && (seenNext >= effLen)
             && (((winNext ^ pattern) & lenMask) == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winQ  <= '0;
      seenQ <= '0;
      found <= 1'b0;
    end else if (clear) begin
      winQ  <= '0;
      seenQ <= '0;
      found <= 1'b0;
    end else begin
      if (!found && bitValid) begin
        winQ  <= winNext;
        seenQ <= seenNext;
      end
      if (hit) found <= 1'b1;
    end
  end

  // R4: once recognised, the flag holds until clear.
  a_r4_found_holds: assert property (@(posedge clk) disable iff (!rstN)
    found && !clear |=> found);

  // R2: the flag can only rise after a full-length window was received.
  a_r2_enough_bits: assert property (@(posedge clk) disable iff (!rstN)
    $rose(found) |-> seenQ >= $past(effLen));

endmodule

// File: rtl/rxCtrl.sv
module rxCtrl
  import syncRxBitFifo_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      clear,
  input  logic      bitValid,
  input  logic      found,
  input  logic      hostSel,
  input  logic      hostSck,
  input  logic      empty,
  input  logic      full,
  output storeCmd_t cmd
);

  logic sckQ;
  logic rdEdge;
  logic arrive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckQ <= 1'b0;
    else       sckQ <= hostSck;
  end

  // Host read edge counts only while selected (R7, R8).
  assign rdEdge = hostSel && hostSck && !sckQ && !clear;
  // The bit that completes the word sees found still low, so it is not stored (R3).
  assign arrive = bitValid && found && !clear;

  always_comb begin
    cmd         = '0;
    cmd.flush   = clear;
    cmd.readEvt = rdEdge;
    cmd.pop     = rdEdge && !empty;
    cmd.push    = arrive && (!full || cmd.pop);
    cmd.drop    = arrive && full && !cmd.pop;
  end

  // R8: a deselected host never removes data.
  a_r8_no_pop_unselected: assert property (@(posedge clk) disable iff (!rstN)
    !hostSel |-> !cmd.pop);

endmodule

// File: rtl/bitStore.sv
module bitStore
  import syncRxBitFifo_pkg::*;
#(
  parameter int DEPTH   = 16,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  storeCmd_t        cmd,
  input  logic             bitIn,
  input  logic [CNT_W-1:0] thresh,
  output logic [CNT_W-1:0] level,
  output logic             empty,
  output logic             full,
  output logic             rdBit,
  output logic             fillIrq,
  output logic             overflow
);

  logic [DEPTH-1:0] mem;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] effThr;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (level == '0);
  assign full  = (level == CNT_W'(DEPTH));

  // Threshold clamp (R6).
  always_comb begin
    if (thresh == '0)                 effThr = CNT_W'(1);
    else if (thresh > CNT_W'(DEPTH))  effThr = CNT_W'(DEPTH);
    else                              effThr = thresh;
  end

  assign fillIrq = (level >= effThr);

  // One storage flop per entry, written when the tail points at it.
  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                         mem[i] <= 1'b0;
      else if (cmd.push && !cmd.flush && wrPtr == PTR_W'(i)) mem[i] <= bitIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      level    <= '0;
      rdBit    <= 1'b0;
      overflow <= 1'b0;
    end else if (cmd.flush) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      level    <= '0;
      rdBit    <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (cmd.push) wrPtr <= ptrInc(wrPtr);
      if (cmd.pop)  rdPtr <= ptrInc(rdPtr);
      case ({cmd.push, cmd.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (cmd.readEvt) rdBit <= cmd.pop ? mem[rdPtr] : 1'b0;
      if (cmd.drop)    overflow <= 1'b1;
    end
  end

  // R5: the count never exceeds the depth.
  a_r5_level_bounded: assert property (@(posedge clk) disable iff (!rstN)
    level <= CNT_W'(DEPTH));

  // R9: overflow is sticky until a flush.
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !cmd.flush |=> overflow);

  // R10: a flush leaves an empty store with the interrupt down.
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    cmd.flush |=> level == '0 && !fillIrq && !overflow);

  // R7: a read of an empty store returns 0 and leaves it empty.
  a_r7_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    cmd.readEvt && empty && !cmd.push && !cmd.flush |=> rdBit == 1'b0 && level == '0);

endmodule

// File: rtl/syncRxBitFifo.sv
module syncRxBitFifo
  import syncRxBitFifo_pkg::*;
#(
  parameter int SYNC_W   = 16,
  parameter int MIN_LEN  = 8,
  parameter int DEPTH    = 16,
  localparam int LEN_W   = $clog2(SYNC_W + 1),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              bitIn,
  input  logic              bitValid,
  input  logic [SYNC_W-1:0] syncPattern,
  input  logic [LEN_W-1:0]  syncLen,
  input  logic [CNT_W-1:0]  fillThresh,
  input  logic              hostSel,
  input  logic              hostSck,
  output logic              rdBit,
  output logic              fillIrq,
  output logic              syncFound,
  output logic              overflow
);

  storeCmd_t        cmd;
  logic             empty, full;
  logic [CNT_W-1:0] level;

  syncMatcher #(.SYNC_W(SYNC_W), .MIN_LEN(MIN_LEN)) u_match (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (clear),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .pattern  (syncPattern),
    .lenCfg   (syncLen),
    .found    (syncFound)
  );

  rxCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (clear),
    .bitValid (bitValid),
    .found    (syncFound),
    .hostSel  (hostSel),
    .hostSck  (hostSck),
    .empty    (empty),
    .full     (full),
    .cmd      (cmd)
  );

  bitStore #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .bitIn    (bitIn),
    .thresh   (fillThresh),
    .level    (level),
    .empty    (empty),
    .full     (full),
    .rdBit    (rdBit),
    .fillIrq  (fillIrq),
    .overflow (overflow)
  );

  // R3: the count can only grow once the word had been recognised.
  a_r3_gated_store: assert property (@(posedge clk) disable iff (!rstN)
    level > $past(level) |-> $past(syncFound));

endmodule

// File: tb/sim_syncRxBitFifo.sv
module sim_syncRxBitFifo;

  logic        clk = 1'b0;
  logic        rstN, clear, bitIn, bitValid, hostSel, hostSck;
  logic [15:0] syncPattern;
  logic [4:0]  syncLen, fillThresh;
  logic        rdBit, fillIrq, syncFound, overflow;

  always #10 clk = ~clk;

  syncRxBitFifo u0 (
    .clk(clk), .rstN(rstN), .clear(clear), .bitIn(bitIn), .bitValid(bitValid),
    .syncPattern(syncPattern), .syncLen(syncLen), .fillThresh(fillThresh),
    .hostSel(hostSel), .hostSck(hostSck), .rdBit(rdBit), .fillIrq(fillIrq),
    .syncFound(syncFound), .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model state
  bit          mq[$];
  logic [15:0] mWin;
  int          mSeen, effLen, effThr;
  bit          mFound, mOvf, mRd;
  logic [15:0] lfsr = 16'hACE1;

  function automatic bit nextNoise();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chkAll(string req);
    chk({req, " syncFound"}, syncFound, mFound);
    chk({req, " fillIrq R6"}, fillIrq, mq.size() >= effThr);
    chk({req, " overflow R9"}, overflow, mOvf);
    chk({req, " rdBit"}, rdBit, mRd);
  endtask

  task automatic setCfg(logic [15:0] pat, int len, int thr);
    @(negedge clk);
    syncPattern = pat;
    syncLen     = 5'(len);
    fillThresh  = 5'(thr);
    effLen = (len < 8) ? 8 : (len > 16) ? 16 : len;
    effThr = (thr == 0) ? 1 : (thr > 16) ? 16 : thr;
  endtask

  task automatic sendBit(bit b);
    int mask;
    @(negedge clk);
    bitIn = b; bitValid = 1'b1;
    @(negedge clk);
    bitValid = 1'b0;
    if (!mFound) begin
      mWin = {mWin[14:0], b};
      if (mSeen < 16) mSeen++;
      mask = (1 << effLen) - 1;
      if (mSeen >= effLen && ((mWin ^ syncPattern) & mask[15:0]) == 16'h0) mFound = 1;
    end else if (mq.size() < 16) begin
      mq.push_back(b);
    end else begin
      mOvf = 1;
    end
    chkAll("R1 R3 R5");
  endtask

  task automatic idleBit();  // data wiggles with valid low (R5)
    @(negedge clk);
    bitIn = ~bitIn; bitValid = 1'b0;
    @(negedge clk);
    chkAll("R5 idle");
  endtask

  task automatic readBit();
    @(negedge clk);
    hostSel = 1'b1; hostSck = 1'b1;
    @(negedge clk);
    if (mq.size() > 0) mRd = mq.pop_front(); else mRd = 0;
    hostSck = 1'b0;
    chkAll("R7 read");
    @(negedge clk);
  endtask

  task automatic unselectedRead();
    @(negedge clk);
    hostSel = 1'b0; hostSck = 1'b1;
    @(negedge clk);
    hostSck = 1'b0;
    @(negedge clk);
    chkAll("R8 deselected");
  endtask

  task automatic clearPulse();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    mq.delete(); mWin = '0; mSeen = 0; mFound = 0; mOvf = 0; mRd = 0;
    chkAll("R10 clear");
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; clear = 0; bitIn = 0; bitValid = 0; hostSel = 0; hostSck = 0;
    syncPattern = '0; syncLen = 5'd8; fillThresh = 5'd8;
    mWin = '0; mSeen = 0; mFound = 0; mOvf = 0; mRd = 0; effLen = 8; effThr = 8;
    repeat (3) @(negedge clk);
    chk("R11 reset rdBit", rdBit, 1'b0);
    chk("R11 reset fillIrq", fillIrq, 1'b0);
    chk("R11 reset syncFound", syncFound, 1'b0);
    chk("R11 reset overflow", overflow, 1'b0);
    rstN = 1'b1;

    // Sweep every length against every threshold.
    for (int len = 8; len <= 16; len++) begin
      for (int thr = 1; thr <= 16; thr++) begin
        logic [15:0] pat;
        int nData;
        pat   = 16'hB38D ^ 16'(len * 16'h1357) ^ 16'(thr * 16'h0F1);
        nData = 12 + ((len + thr) % 8);
        clearPulse();
        setCfg(pat, len, thr);
        for (int i = 0; i < 20; i++) sendBit(nextNoise());
        idleBit();
        for (int i = len - 1; i >= 0; i--) sendBit(pat[i]);
        for (int i = 0; i < nData; i++) sendBit(nextNoise());
        unselectedRead();
        for (int i = 0; i < 18; i++) readBit();
      end
    end

    // R2: all-zero word is not recognised before L bits, with clamped length and threshold.
    clearPulse();
    setCfg(16'h0000, 3, 0);
    for (int i = 0; i < 7; i++) sendBit(1'b0);
    chk("R2 zero word early", syncFound, 1'b0);
    sendBit(1'b0);
    chk("R2 zero word at L", syncFound, 1'b1);
    sendBit(1'b1);
    chk("R6 thresh 0 acts as 1", fillIrq, 1'b1);
    readBit();
    chk("R7 first stored bit", rdBit, 1'b1);

    // Threshold above 16 clamps to 16; overflow at exactly 16.
    clearPulse();
    setCfg(16'h5A3C, 20, 20);
    for (int i = 15; i >= 0; i--) sendBit(syncPattern[i]);
    for (int i = 0; i < 16; i++) sendBit(i[0]);
    chk("R6 irq at 16", fillIrq, 1'b1);
    chk("R9 no overflow at 16", overflow, 1'b0);
    sendBit(1'b1);
    chk("R9 overflow set", overflow, 1'b1);
    readBit();
    chk("R6 irq below 16", fillIrq, 1'b0);
    chk("R9 overflow sticky", overflow, 1'b1);
    for (int i = 0; i < 16; i++) readBit();
    clearPulse();
    readBit();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule